// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block lets an external bus master take the system bus away from the processor. The master pulls an active-low request line. The arbiter looks at that request only at a falling edge of the bus clock, and only when no bus cycle is running. It then answers on an active-low acknowledge line and stops the CPU clock enable. One bus clock after acknowledge falls, it turns off the output enables of the address, strobe and data drivers. When the master lets go of its request, acknowledge returns high. One bus clock later the drivers are enabled again, and the CPU resumes at the same moment.

A single fast fabric clock runs the whole block. The bus clock arrives as a level that is synchronous to that fabric clock. Every falling transition seen on it counts as one bus-clock step. A request that shows up while a bus cycle is in progress is not granted. The arbiter looks at it again at every later step and grants it at the first step where the bus is free, as long as the request is still held low. In 8-bit bus mode the upper data lanes are not bus pins, so their enables stay on through hold.

Top module: `bus_hold_arbiter`

## Requirements
- R1: During and directly after synchronous reset, `hold_ack_n` is 1, every bit of `addr_oe`, `strobe_oe` and `data_oe` is 1, and `cpu_clk_en` is 1.
- R2: `hold_ack_n` goes from 1 to 0 only in the fabric cycle after a bus-clock falling step (`bus_phi` sampled 1 then 0) at which `hold_req_n` was 0 and `bus_busy` was 0.
- R3: A request present at a falling step with `bus_busy` at 1 is not granted at that step. It is granted at the first later falling step where `bus_busy` is 0, provided `hold_req_n` is still 0.
- R4: `cpu_clk_en` is 0 whenever `hold_ack_n` is 0 and whenever any driver enable is 0. It returns to 1 together with the driver enables.
- R5: The address enables, all three strobe enables (bit 0 read, bit 1 write, bit 2 byte-high) and data lane 0 go to 0 at the first falling step after `hold_ack_n` went to 0, unless the request was withdrawn by that step.
- R6: After `hold_ack_n` returns to 1 with the drivers off, those enables return to 1 at the next falling step.
- R7: While in hold, a falling step with `hold_req_n` at 1 sets `hold_ack_n` to 1 in the following fabric cycle. `bus_busy` is ignored while hold is active.
- R8: Data lanes at index NARROW_LANES and above are 1 while `narrow_bus` was 1 at the previous clock edge. Otherwise they follow lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_phi | input | 1 | Bus clock level, synchronous to clk |
| bus_busy | input | 1 | High while a bus cycle is in progress |
| hold_req_n | input | 1 | Active-low hold request from the external master |
| narrow_bus | input | 1 | 1 selects the 8-bit bus, which keeps the upper lanes driven |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| addr_oe | output | ADDR_GRP | Address driver enables, 1 = driven |
| strobe_oe | output | 3 | Read, write, byte-high driver enables |
| data_oe | output | NUM_DLANES | Per-lane data driver enables |
| cpu_clk_en | output | 1 | CPU clock enable, 0 holds the CPU clock low |

## Verification
The hardest situations to reach are the short-lived ones. The first is a request withdrawn in the single bus clock between grant and float, so acknowledge rises without the drivers ever switching off. The second is a request that waits across several busy bus cycles and is then granted at exactly the first idle falling step. Directed phases hold the bus busy across many bus-clock periods with the request low and then free it. A long random phase uses bus-clock half-periods of varying length and frequent request toggling, so that withdrawals land inside the one-step window. A bench reference model, updated every fabric edge, predicts every output.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;

  // Hold sequencing states; order is not decoded anywhere else.
  typedef enum logic [1:0] {
    HS_RUN     = 2'd0,  // CPU owns the bus
    HS_ACK     = 2'd1,  // acknowledge low, drivers still on
    HS_FLOAT   = 2'd2,  // acknowledge low, drivers off
    HS_REDRIVE = 2'd3   // acknowledge high, drivers still off
  } hold_st_t;

  localparam int unsigned STROBE_W = 3;  // read, write, byte-high

endpackage

// File: rtl/bus_fall_det.sv
module bus_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic bus_phi,
  output logic fall_tick
);

  logic phi_q;

  always_ff @(posedge clk) begin
    if (rst) phi_q <= 1'b0;
    else     phi_q <= bus_phi;
  end

  assign fall_tick = phi_q & ~bus_phi;

  // R2: a step cannot repeat in back-to-back cycles (needs a high level in between)
  // R2
  fall_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    fall_tick |=> !fall_tick);

endmodule

// File: rtl/bus_hold_fsm.sv
module bus_hold_fsm
  import bus_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     bus_busy,
  input  logic     hold_req_n,
  output hold_st_t state,
  output logic     drv_on_nxt,
  output logic     hold_ack_n,
  output logic     cpu_en
);

  hold_st_t nxt;

  always_comb begin
    nxt = state;
    if (tick) begin
      unique case (state)
        HS_RUN:     if (!hold_req_n && !bus_busy) nxt = HS_ACK;
        HS_ACK:     nxt = hold_req_n ? HS_RUN : HS_FLOAT;
        HS_FLOAT:   if (hold_req_n) nxt = HS_REDRIVE;
        HS_REDRIVE: nxt = HS_RUN;
        default:    nxt = HS_RUN;
      endcase
    end
  end

  assign drv_on_nxt = (nxt != HS_FLOAT) && (nxt != HS_REDRIVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= HS_RUN;
      hold_ack_n <= 1'b1;
      cpu_en     <= 1'b1;
    end else begin
      state      <= nxt;
      hold_ack_n <= !((nxt == HS_ACK) || (nxt == HS_FLOAT));
      cpu_en     <= (nxt == HS_RUN);
    end
  end

  // R2
  grant_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_ack_n) |-> $past(tick && !bus_busy && !hold_req_n));

  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && bus_busy && hold_ack_n) |=> hold_ack_n);

  // R3
  idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_busy && !hold_req_n && state == HS_RUN) |=> !hold_ack_n);

  // R7
  release_cond_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ack_n) |-> $past(tick && hold_req_n));

  // R7
  release_done_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && hold_req_n && !hold_ack_n) |=> hold_ack_n);

endmodule

// File: rtl/bus_drv_enables.sv
module bus_drv_enables #(
  parameter int unsigned ADDR_GRP     = 3,
  parameter int unsigned NUM_DLANES   = 2,
  parameter int unsigned NARROW_LANES = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  drv_on_nxt,
  input  logic                  narrow_bus,
  output logic [ADDR_GRP-1:0]   addr_oe,
  output logic [bus_hold_pkg::STROBE_W-1:0] strobe_oe,
  output logic [NUM_DLANES-1:0] data_oe
);

  localparam int unsigned SW = bus_hold_pkg::STROBE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_oe   <= '1;
      strobe_oe <= '1;
    end else begin
      addr_oe   <= {ADDR_GRP{drv_on_nxt}};
      strobe_oe <= {SW{drv_on_nxt}};
    end
  end

  for (genvar g = 0; g < NUM_DLANES; g++) begin : g_lane
    if (g < NARROW_LANES) begin : g_low
      always_ff @(posedge clk) begin
        if (rst) data_oe[g] <= 1'b1;
        else     data_oe[g] <= drv_on_nxt;
      end
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst) data_oe[g] <= 1'b1;
        else     data_oe[g] <= drv_on_nxt | narrow_bus;
      end
      // R8
      narrow_keep_chk: assert property (@(posedge clk) disable iff (rst)
        $past(narrow_bus) |-> data_oe[g]);
    end
  end

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int unsigned ADDR_GRP     = 3,
  parameter int unsigned NUM_DLANES   = 2,
  parameter int unsigned NARROW_LANES = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_phi,
  input  logic                  bus_busy,
  input  logic                  hold_req_n,
  input  logic                  narrow_bus,
  output logic                  hold_ack_n,
  output logic [ADDR_GRP-1:0]   addr_oe,
  output logic [2:0]            strobe_oe,
  output logic [NUM_DLANES-1:0] data_oe,
  output logic                  cpu_clk_en
);
  import bus_hold_pkg::*;

  logic     tick;
  logic     drv_on_nxt;
  hold_st_t state;

  bus_fall_det u_fall (
    .clk       (clk),
    .rst       (rst),
    .bus_phi   (bus_phi),
    .fall_tick (tick)
  );

  bus_hold_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .bus_busy   (bus_busy),
    .hold_req_n (hold_req_n),
    .state      (state),
    .drv_on_nxt (drv_on_nxt),
    .hold_ack_n (hold_ack_n),
    .cpu_en     (cpu_clk_en)
  );

  bus_drv_enables #(
    .ADDR_GRP     (ADDR_GRP),
    .NUM_DLANES   (NUM_DLANES),
    .NARROW_LANES (NARROW_LANES)
  ) u_drv (
    .clk        (clk),
    .rst        (rst),
    .drv_on_nxt (drv_on_nxt),
    .narrow_bus (narrow_bus),
    .addr_oe    (addr_oe),
    .strobe_oe  (strobe_oe),
    .data_oe    (data_oe)
  );

  // R1
  reset_out_chk: assert property (@(posedge clk)
    $past(rst) |-> (hold_ack_n && (&addr_oe) && (&strobe_oe) && (&data_oe) && cpu_clk_en));

  // R4
  cpu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold_ack_n || !addr_oe[0]) |-> !cpu_clk_en);

  // R5
  float_lag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(addr_oe[0]) |-> $past(tick && !hold_ack_n));

  // R6
  redrive_lag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_oe[0]) |-> $past(tick && hold_ack_n));

  // R4
  cpu_resume_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk_en) |-> addr_oe[0]);

endmodule

// File: tb/bus_hold_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_hold_arbiter_tb_top;

  localparam int unsigned AG = 3;
  localparam int unsigned NL = 2;
  localparam int unsigned NN = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_phi = 1'b1;
  logic bus_busy = 1'b0;
  logic hold_req_n = 1'b1;
  logic narrow_bus = 1'b0;
  logic hold_ack_n;
  logic [AG-1:0] addr_oe;
  logic [2:0] strobe_oe;
  logic [NL-1:0] data_oe;
  logic cpu_clk_en;

  int total = 0;
  int bad = 0;
  int phi_cnt = 2;
  int phi_min = 1;
  int phi_max = 4;
  bit timeout = 0;

  // reference model state: 0 run, 1 ack, 2 float, 3 redrive
  int  m_st = 0;
  bit  m_phq = 0;
  bit  m_ack = 1, m_drv = 1, m_cpu = 1, m_hi = 1;

  always #2.5 clk = ~clk;

  bus_hold_arbiter #(.ADDR_GRP(AG), .NUM_DLANES(NL), .NARROW_LANES(NN)) dut_i (
    .clk(clk), .rst(rst), .bus_phi(bus_phi), .bus_busy(bus_busy),
    .hold_req_n(hold_req_n), .narrow_bus(narrow_bus), .hold_ack_n(hold_ack_n),
    .addr_oe(addr_oe), .strobe_oe(strobe_oe), .data_oe(data_oe), .cpu_clk_en(cpu_clk_en)
  );

  function automatic int next_st(int st, bit tk, bit busy, bit req_n);
    if (!tk) return st;
    case (st)
      0: return (!req_n && !busy) ? 1 : 0;
      1: return req_n ? 0 : 2;
      2: return req_n ? 3 : 2;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_phq = 0; m_ack = 1; m_drv = 1; m_cpu = 1; m_hi = 1;
    end else begin
      m_st  = next_st(m_st, m_phq & ~bus_phi, bus_busy, hold_req_n);
      m_phq = bus_phi;
      m_ack = !(m_st == 1 || m_st == 2);
      m_drv = !(m_st == 2 || m_st == 3);
      m_cpu = (m_st == 0);
      m_hi  = m_drv | narrow_bus;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(bit in_reset);
    logic [31:0] lo_exp;
    lo_exp = {31'd0, m_drv};
    if (in_reset) begin
      chk("R1 reset ack", {31'd0, hold_ack_n}, 32'd1);
      chk("R1 reset enables", {26'd0, addr_oe, strobe_oe}, 32'h3f);
      chk("R1 reset lanes cpu", {29'd0, data_oe, cpu_clk_en}, 32'd7);
    end else begin
      chk("R2 R3 R7 ack", {31'd0, hold_ack_n}, {31'd0, m_ack});
      chk("R4 cpu enable", {31'd0, cpu_clk_en}, {31'd0, m_cpu});
      chk("R5 R6 addr", {29'd0, addr_oe}, m_drv ? 32'h7 : 32'h0);
      chk("R5 R6 strobes", {29'd0, strobe_oe}, m_drv ? 32'h7 : 32'h0);
      chk("R5 R6 lane0", {31'd0, data_oe[0]}, lo_exp);
      chk("R8 upper lane", {31'd0, data_oe[1]}, {31'd0, m_hi});
    end
  endtask

  task automatic step(bit in_reset);
    @(negedge clk);
    check_all(in_reset);
    phi_cnt--;
    if (phi_cnt <= 0) begin
      bus_phi = ~bus_phi;
      phi_cnt = $urandom_range(phi_max, phi_min);
    end
  endtask

  task automatic run_all();
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) step(1'b1);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) step(1'b0);
    // R3: request pending across a long busy stretch, then bus frees
    bus_busy = 1'b1; hold_req_n = 1'b0;
    for (int i = 0; i < 40; i++) step(1'b0);
    chk("R3 held off while busy", {31'd0, hold_ack_n}, 32'd1);
    bus_busy = 1'b0;
    for (int i = 0; i < 30; i++) step(1'b0);
    chk("R3 granted once idle", {31'd0, hold_ack_n}, 32'd0);
    // R7: busy ignored during hold, then release
    bus_busy = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b0);
    hold_req_n = 1'b1;
    for (int i = 0; i < 30; i++) step(1'b0);
    chk("R6 drivers back", {29'd0, addr_oe}, 32'h7);
    bus_busy = 1'b0;
    // R8: narrow bus keeps upper lane through hold
    narrow_bus = 1'b1; hold_req_n = 1'b0;
    for (int i = 0; i < 40; i++) step(1'b0);
    chk("R8 upper lane on in hold", {31'd0, data_oe[1]}, 32'd1);
    hold_req_n = 1'b1;
    for (int i = 0; i < 30; i++) step(1'b0);
    narrow_bus = 1'b0;
    // withdrawal inside the grant-to-float window, with slow bus clock
    phi_min = 3; phi_max = 3;
    for (int k = 0; k < 8; k++) begin
      while (!(hold_ack_n && bus_phi && phi_cnt == 1)) step(1'b0);
      hold_req_n = 1'b0;
      for (int i = 0; i < 3 + k; i++) step(1'b0);
      hold_req_n = 1'b1;
      for (int i = 0; i < 20; i++) step(1'b0);
    end
    // random phase
    phi_min = 1; phi_max = 4;
    for (int i = 0; i < 20000; i++) begin
      step(1'b0);
      if ($urandom_range(7, 0) == 0) bus_busy = ~bus_busy;
      if ($urandom_range(29, 0) == 0) hold_req_n = ~hold_req_n;
      if ($urandom_range(799, 0) == 0) narrow_bus = ~narrow_bus;
      if ($urandom_range(999, 0) == 0) begin
        phi_min = $urandom_range(3, 1);
        phi_max = phi_min + $urandom_range(5, 0);
      end
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule